// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

This block is a 32-pin general-purpose I/O port that software controls through eight word-indexed registers. Each pin can be driven from an output latch under a per-pin direction bit. Every pad level is brought into the clock domain by a two-stage synchronizer, and the synchronized level can be read back.

Each pin can also raise an interrupt. A 2-bit sense code picks low level, high level, rising edge or falling edge, and a separate per-pin bit overrides the code so that either edge is flagged. A detected event latches into a pending-status bit whether or not the pin is enabled. Software clears a status bit by writing 1 to it. The status is gated by a per-pin enable and reduced onto two registered request lines, one for the lower sixteen pins and one for the upper sixteen. The request lines feed an interrupt controller outside this block.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, the output latch, direction, both sense registers, the enable mask and the any-edge register read 0. `pad_oe` and `pad_out` are 0 and both request lines are low.
- R2: Register indices are 0 output latch, 1 direction, 2 pad levels, 3 sense for pins 0-15, 4 sense for pins 16-31, 5 enable mask, 6 pending status, 7 any-edge select. A read presents `rd_data` in the cycle after `bus_rd`. The output latch drives `pad_out`, the direction register drives `pad_oe`, and a direction bit of 0 leaves the pin an input.
- R3: Index 2 returns the pad levels after a two-flop synchronizer. A level applied at least three cycles before the read is returned. Writes to index 2 have no effect.
- R4: Pin n below 16 takes its sense code from bits [2n+1:2n] of index 3. Pin n of 16 or more takes it from bits [2(n-16)+1:2(n-16)] of index 4. Code 0 flags a low level, 1 a high level, 2 a rising edge and 3 a falling edge. An edge is found by comparing the synchronized level with its previous sample.
- R5: When bit n of index 7 is 1, both rising and falling transitions of pin n set its status bit, and its sense code has no effect.
- R6: Writing 1 to a bit of index 6 clears that status bit, and writing 0 leaves it unchanged. A detection in the same cycle as a clear of the same bit leaves the bit set.
- R7: A pin in a level mode sets its status bit again on every cycle that the level persists, so a clear does not hold while the level remains.
- R8: Status bits latch even when their mask bit is 0. `irq_lo` is the OR of status AND mask over pins 0-15, and `irq_hi` is the same over pins 16-31. Both are registered one cycle after the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch value |
| pad_oe | output | 32 | Per-pin output enable (1 = output) |
| irq_lo | output | 1 | Request for pins 0-15 |
| irq_hi | output | 1 | Request for pins 16-31 |

## Verification
The bench aims at the clear/detect collision. A design that gave the clear priority would drop a level-mode bit that should stay pending. Any-edge pins sit on a low-level code, so a design that let the code leak through would flag a steady low pin. Falling transitions on a rising-sense pin check that a design with a reversed polarity or code table flags the wrong edge. A masked pin is made pending to check that a design gating the latch with the mask would lose the event. A design that swapped the half-port reductions would raise the wrong request line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_LATCH    = 3'd0,
    IDX_DIR      = 3'd1,
    IDX_LEVELS   = 3'd2,
    IDX_SENSE_LO = 3'd3,
    IDX_SENSE_HI = 3'd4,
    IDX_ENABLE   = 3'd5,
    IDX_PENDING  = 3'd6,
    IDX_ANYEDGE  = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      stage1 <= din;
      cur    <= stage1;
      prev   <= cur;
    end
  end

  // prev always trails cur by exactly one cycle
  assert_prev_trails_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prev == $past(cur)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   prev,
  input  logic [2*WIDTH-1:0] sense,
  input  logic [WIDTH-1:0]   any_edge,
  output logic [WIDTH-1:0]   det
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    sense_e code;
    logic   by_code;
    logic   rose;
    logic   fell;

    assign code = sense_e'(sense[2*i +: 2]);
    assign rose = cur[i] & ~prev[i];
    assign fell = ~cur[i] & prev[i];

    always_comb begin
      unique case (code)
        SENSE_LOW:  by_code = ~cur[i];
        SENSE_HIGH: by_code = cur[i];
        SENSE_RISE: by_code = rose;
        default:    by_code = fell;
      endcase
    end

    assign det[i] = any_edge[i] ? (rose | fell) : by_code;
  end

  // any transition on an any-edge pin must be flagged
  assert_anyedge_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (((cur ^ prev) & any_edge & ~det) == '0));
  // a steady any-edge pin never flags, whatever its code
  assert_anyedge_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ((~(cur ^ prev) & any_edge & det) == '0));
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int WIDTH = 32,
  parameter int HALF  = WIDTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] det,
  input  logic [WIDTH-1:0] clr,
  input  logic [WIDTH-1:0] enable,
  output logic [WIDTH-1:0] pending,
  output logic             irq_lo,
  output logic             irq_hi
);
  logic [WIDTH-1:0] gated;
  assign gated = pending & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
    end else begin
      pending <= (pending & ~clr) | det;
      irq_lo  <= |gated[HALF-1:0];
      irq_hi  <= |gated[WIDTH-1:HALF];
    end
  end

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~det) != '0) |=> ((pending & $past(clr & ~det)) == '0));
  assert_detect_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (det != '0) |=> ((pending & $past(det)) == $past(det)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(clr | det)) == ($past(pending) & ~$past(clr | det))));
  assert_irq_lo_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_lo == $past(|(pending[HALF-1:0] & enable[HALF-1:0]))));
  assert_irq_hi_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_hi == $past(|(pending[WIDTH-1:HALF] & enable[WIDTH-1:HALF]))));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [NUM_PINS-1:0]  bus_wdata,
  output logic [NUM_PINS-1:0]  rd_data,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-1:0]  pad_out,
  output logic [NUM_PINS-1:0]  pad_oe,
  output logic                 irq_lo,
  output logic                 irq_hi
);
  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0] latch_q, dir_q, sense_lo_q, sense_hi_q, enable_q, anyedge_q;
  logic [NUM_PINS-1:0] lvl_cur, lvl_prev, det, clr, pending;
  reg_idx_e            idx;

  assign idx = reg_idx_e'(bus_addr);
  assign clr = (bus_wr && idx == IDX_PENDING) ? bus_wdata : '0;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .cur(lvl_cur), .prev(lvl_prev)
  );

  gpio_detect #(.WIDTH(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .cur(lvl_cur), .prev(lvl_prev),
    .sense({sense_hi_q, sense_lo_q}), .any_edge(anyedge_q), .det(det)
  );

  gpio_status #(.WIDTH(NUM_PINS), .HALF(HALF)) u_status (
    .clk(clk), .rst(rst), .det(det), .clr(clr), .enable(enable_q),
    .pending(pending), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      dir_q      <= '0;
      sense_lo_q <= '0;
      sense_hi_q <= '0;
      enable_q   <= '0;
      anyedge_q  <= '0;
    end else if (bus_wr) begin
      unique case (idx)
        IDX_LATCH:    latch_q    <= bus_wdata;
        IDX_DIR:      dir_q      <= bus_wdata;
        IDX_SENSE_LO: sense_lo_q <= bus_wdata;
        IDX_SENSE_HI: sense_hi_q <= bus_wdata;
        IDX_ENABLE:   enable_q   <= bus_wdata;
        IDX_ANYEDGE:  anyedge_q  <= bus_wdata;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (bus_rd) begin
      unique case (idx)
        IDX_LATCH:    rd_data <= latch_q;
        IDX_DIR:      rd_data <= dir_q;
        IDX_LEVELS:   rd_data <= lvl_cur;
        IDX_SENSE_LO: rd_data <= sense_lo_q;
        IDX_SENSE_HI: rd_data <= sense_hi_q;
        IDX_ENABLE:   rd_data <= enable_q;
        IDX_PENDING:  rd_data <= pending;
        default:      rd_data <= anyedge_q;
      endcase
    end
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;

  // a read of the level register returns the synchronized pads
  assert_levels_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && idx == IDX_LEVELS) |=> (rd_data == $past(lvl_cur)));
  // writes to the level register leave all writable state alone
  assert_levels_ro_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && idx == IDX_LEVELS) |=>
      ($stable(latch_q) && $stable(dir_q) && $stable(enable_q) && $stable(anyedge_q)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] rd_data, pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_prev, m_latch, m_dir, m_slo, m_shi, m_en, m_any, m_pend;
  logic        m_irq_lo, m_irq_hi;

  function automatic logic [31:0] f_det(input logic [31:0] c, input logic [31:0] p,
                                        input logic [31:0] lo, input logic [31:0] hi,
                                        input logic [31:0] any);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] code;
      code = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      if (any[i]) r[i] = c[i] ^ p[i];
      else case (code)
        2'd0: r[i] = ~c[i];
        2'd1: r[i] = c[i];
        2'd2: r[i] = c[i] & ~p[i];
        default: r[i] = ~c[i] & p[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_latch;
      3'd1: return m_dir;
      3'd2: return m_s2;
      3'd3: return m_slo;
      3'd4: return m_shi;
      3'd5: return m_en;
      3'd6: return m_pend;
      default: return m_any;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] d, c;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_latch <= '0; m_dir <= '0;
      m_slo <= '0; m_shi <= '0; m_en <= '0; m_any <= '0; m_pend <= '0;
      m_irq_lo <= 1'b0; m_irq_hi <= 1'b0;
    end else begin
      d = f_det(m_s2, m_prev, m_slo, m_shi, m_any);
      c = (bus_wr && bus_addr == 3'd6) ? bus_wdata : '0;
      m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_pend <= (m_pend & ~c) | d;
      m_irq_lo <= |(m_pend[15:0] & m_en[15:0]);
      m_irq_hi <= |(m_pend[31:16] & m_en[31:16]);
      if (bus_wr) case (bus_addr)
        3'd0: m_latch <= bus_wdata;
        3'd1: m_dir <= bus_wdata;
        3'd3: m_slo <= bus_wdata;
        3'd4: m_shi <= bus_wdata;
        3'd5: m_en <= bus_wdata;
        3'd7: m_any <= bus_wdata;
        default: ;
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, output logic [31:0] v);
    logic [31:0] exp;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; exp = m_read(a);
    @(negedge clk);
    bus_rd = 1'b0;
    v = rd_data;
    check(tag, v, exp);
  endtask

  task automatic check_outs(input string tag);
    check({tag, " pad_out"}, pad_out, m_latch);
    check({tag, " pad_oe"}, pad_oe, m_dir);
    check({tag, " irq"}, {30'd0, irq_hi, irq_lo}, {30'd0, m_irq_hi, m_irq_lo});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd20240611));
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    foreach (v[i]) ;
    rd(3'd0, "R1 latch", v); check("R1 latch zero", v, 0);
    rd(3'd1, "R1 dir", v);   check("R1 dir zero", v, 0);
    rd(3'd3, "R1 sense lo", v); check("R1 sense lo zero", v, 0);
    rd(3'd4, "R1 sense hi", v); check("R1 sense hi zero", v, 0);
    rd(3'd5, "R1 enable", v); check("R1 enable zero", v, 0);
    rd(3'd7, "R1 anyedge", v); check("R1 anyedge zero", v, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irqs", {30'd0, irq_hi, irq_lo}, 0);

    // R2 output latch and direction
    wr(3'd0, 32'hA5A5_0F0F);
    wr(3'd1, 32'hFFFF_0000);
    rd(3'd0, "R2 latch", v); check("R2 latch value", v, 32'hA5A5_0F0F);
    rd(3'd1, "R2 dir", v);   check("R2 dir value", v, 32'hFFFF_0000);
    check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);

    // R3 synchronized pad levels, read-only
    pad_in = 32'h1234_8001;
    idle(3);
    rd(3'd2, "R3 levels", v); check("R3 levels value", v, 32'h1234_8001);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, "R3 levels after write", v); check("R3 levels unchanged", v, 32'h1234_8001);
    rd(3'd0, "R3 latch after write", v); check("R3 latch untouched", v, 32'hA5A5_0F0F);

    // R4 rising sense, masked pin still latches (R8)
    wr(3'd3, 32'hAAAA_AAAA);
    wr(3'd4, 32'hAAAA_AAAA);
    pad_in = '0;
    idle(4);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, "R4 cleared", v); check("R4 no pending", v, 0);
    pad_in = 32'h0000_0020;
    idle(4);
    rd(3'd6, "R4 rise", v); check("R4 rising pin 5", v, 32'h0000_0020);
    check("R8 masked no irq", {30'd0, irq_hi, irq_lo}, 0);

    // R8 enable raises low-half request only
    wr(3'd5, 32'h0000_0020);
    idle(2);
    check("R8 irq_lo up", {31'd0, irq_lo}, 1);
    check("R8 irq_hi down", {31'd0, irq_hi}, 0);

    // R6 write-one-to-clear
    wr(3'd6, 32'h0000_0000);
    rd(3'd6, "R6 zero write", v); check("R6 zero keeps", v, 32'h0000_0020);
    wr(3'd6, 32'h0000_0020);
    rd(3'd6, "R6 one write", v); check("R6 one clears", v, 0);
    idle(1);
    check("R8 irq_lo drops", {31'd0, irq_lo}, 0);

    // R4 falling edge ignored under rising code
    pad_in = '0;
    idle(4);
    rd(3'd6, "R4 fall ignored", v); check("R4 no flag on fall", v, 0);

    // R7 level-high on pin 20 survives a clear; R6 detection beats clear
    wr(3'd4, 32'hAAAA_A9AA);
    pad_in = 32'h0010_0000;
    idle(4);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, "R7 level", v); check("R7 level re-sets pin 20", v & 32'h0010_0000, 32'h0010_0000);
    wr(3'd5, 32'h0010_0000);
    idle(2);
    check("R8 irq_hi up", {31'd0, irq_hi}, 1);
    check("R8 irq_lo idle", {31'd0, irq_lo}, 0);

    // R5 any-edge overrides low-level code on pin 9
    wr(3'd3, 32'hAAA2_AAAA);
    wr(3'd7, 32'h0000_0200);
    idle(2);
    wr(3'd6, 32'hFFFF_FFFF);
    idle(2);
    rd(3'd6, "R5 steady low", v); check("R5 code ignored", v & 32'h200, 0);
    pad_in = 32'h0010_0200;
    idle(4);
    rd(3'd6, "R5 rise", v); check("R5 rise flagged", v & 32'h200, 32'h200);
    wr(3'd6, 32'h0000_0200);
    pad_in = 32'h0010_0000;
    idle(4);
    rd(3'd6, "R5 fall", v); check("R5 fall flagged", v & 32'h200, 32'h200);

    // random phase against the model (R1..R8)
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: wr(3'($urandom % 8), $urandom);
        1: rd(3'($urandom % 8), "R2 random read", v);
        2: begin @(negedge clk); pad_in = pad_in ^ ($urandom & $urandom); end
        3: wr(3'd6, $urandom);
        4: rd(3'd6, "R6 random pending", v);
        default: idle(1);
      endcase
      check_outs("R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule